// File: doc/BRIEF.md
# Power-Aware Successive-Approximation Conversion Controller

This block sequences an 8-bit successive-approximation conversion on one of four analog inputs inside a small microcontroller. Software writes a control word that carries a start bit, the channel, the converter clock source, an interrupt enable and a flag-clear bit. The controller steers the analog input multiplexer and walks the DAC trial code from the MSB to the LSB, keeping or dropping each bit according to a comparator input. It stores the final code in a result register, sets a completion flag and raises an interrupt.

The controller also watches the CPU's Idle and Power Down requests. In Idle, the conversion runs on. In Power Down it runs on only when the free-running RC oscillator is the converter clock. When the CPU clock is the converter clock and Power Down is requested, the conversion is dropped at once: no wake is sent and the result is marked invalid. A conversion that completes while the CPU sleeps sends a wake pulse if the interrupt is enabled.

The RC oscillator reaches the block as a one-cycle tick. Starting on that source costs a fixed synchronisation delay of SYNC_CYC cycles. An RC start while the CPU clock is flagged as faster than 4 MHz is refused and reported.

The sequencer has four states. IDLE waits for a start. SYNC covers the synchronisation delay on the RC source. CONV makes one bit decision per converter tick. DONE writes the result. The transitions are:
- IDLE to SYNC on an accepted start with the RC source.
- IDLE to CONV on an accepted start with the CPU source.
- SYNC to CONV after SYNC_CYC cycles.
- CONV to DONE on the tick that decides bit 0.
- DONE to IDLE always.
- SYNC, CONV or DONE to IDLE on an abort.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: On an accepted start, `mux_sel` takes the 2-bit channel field (0 selects input 0, 1 input 1, 2 input 2, 3 input 3). It holds that value for the whole conversion, even if later writes carry another channel.
- R2: The conversion makes 8 decisions, from bit 7 down to bit 0. `dac_code` shows the bits already kept with the bit under trial set. A comparator value of 1 keeps the trial bit, and 0 clears it. With `cmp_in = (input >= dac_code)`, the stored result equals the 8-bit input value.
- R3: The clock source is chosen by `ctl_rcsel`: 0 selects the CPU clock and 1 selects the RC oscillator. On the CPU source `busy` is high for exactly 9 cycles after the start write. On the RC source it is high for SYNC_CYC+9 cycles when `rc_tick` is high every cycle, and the result is also correct when `rc_tick` is sparse.
- R4: `busy` is high from the start until the result is written. A start write while busy is ignored.
- R5: `done_flag` is set when a result is written and cleared by a write with `ctl_flag_clr` = 1. `irq` equals `done_flag` AND the enable written through `ctl_ie`.
- R6: `result_valid` is set by a completed conversion and cleared by an abort.
- R7: Under `idle_req` the conversion completes. `wake` pulses for one cycle at completion if the interrupt is enabled, and stays low otherwise.
- R8: Under `pdown_req` with the RC source, the conversion completes and `wake` pulses if the interrupt is enabled.
- R9: Under `pdown_req` with the CPU source, a running conversion aborts on the next edge. When that happens, `busy` drops, `done_flag` is not set, `wake` stays low, `result_valid` clears and `result` keeps its old value.
- R10: A start with `ctl_rcsel` = 1 while `cpu_fast` = 1 is refused and sets `cfg_err`. The next accepted start clears `cfg_err`.
- R11: After reset, `busy`, `done_flag`, `irq`, `wake`, `result_valid`, `cfg_err`, `mux_sel` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_start | input | 1 | Start bit of the control word |
| ctl_chan | input | CH_W (2) | Channel field |
| ctl_rcsel | input | 1 | Clock source: 0 = CPU, 1 = RC |
| ctl_ie | input | 1 | Interrupt enable |
| ctl_flag_clr | input | 1 | Clears the completion flag |
| cpu_fast | input | 1 | CPU clock above 4 MHz |
| rc_tick | input | 1 | RC oscillator tick |
| idle_req | input | 1 | CPU is in Idle |
| pdown_req | input | 1 | CPU is in Power Down |
| cmp_in | input | 1 | Comparator: input at or above DAC code |
| mux_sel | output | CH_W (2) | Analog multiplexer select |
| dac_code | output | RES_W (8) | Trial code to the DAC |
| result | output | RES_W (8) | Result register |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | One-cycle CPU wake pulse |
| result_valid | output | 1 | Result is valid |
| cfg_err | output | 1 | Refused RC start |

## Verification
The bench builds the block with its default parameters: RES_W = 8, CH_W = 2 and SYNC_CYC = 4. At these values every one of the 256 input codes can be converted on each of the four channels with the CPU source, and all 256 codes again with a sparse RC tick. Each expected result is simply the input code. Each busy length is 9, or SYNC_CYC + 9, which makes cycle-exact timing checks cheap. The small size also leaves room to try every pairing of the sleep requests, clock source and interrupt enable.

// File: rtl/adc_pkg.sv
package adc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_CONV,
        ST_DONE
    } adc_state_t;
endpackage

// File: rtl/adc_sync_cnt.sv
module adc_sync_cnt #(
    parameter int SYNC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(SYNC_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && (cnt_q == CW'(SYNC_CYC - 1));
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] acc,
    output logic             last
);
    localparam int IW = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic [RES_W-1:0] acc_q;
    logic [IW-1:0]    idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            idx_q <= '0;
        end else if (load) begin
            acc_q <= '0;
            idx_q <= IW'(RES_W - 1);
        end else if (step) begin
            acc_q[idx_q] <= cmp_in;
            if (idx_q != '0)
                idx_q <= idx_q - 1'b1;
        end
    end

    for (genvar i = 0; i < RES_W; i++) begin : g_trial
        assign trial[i] = acc_q[i] | (idx_q == IW'(i));
    end

    assign acc  = acc_q;
    assign last = (idx_q == '0);

    a_r2_bit_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && idx_q != '0) |=> (idx_q == $past(idx_q) - 1'b1));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic            ctl_start,
    input  logic [CH_W-1:0] ctl_chan,
    input  logic            ctl_rcsel,
    input  logic            cpu_fast,
    input  logic            rc_tick,
    input  logic            pdown_req,
    input  logic            sync_last,
    input  logic            sar_last,
    output logic [CH_W-1:0] chan,
    output logic            busy,
    output logic            sync_run,
    output logic            sar_load,
    output logic            sar_step,
    output logic            done_evt,
    output logic            abort_evt,
    output logic            start_ok,
    output logic            start_bad
);
    adc_state_t      state_q, state_d;
    logic            src_rc_q;
    logic [CH_W-1:0] chan_q;
    logic            in_idle, start_req, conv_tick;

    assign in_idle   = (state_q == ST_IDLE);
    assign start_req = ctl_we && ctl_start && in_idle;
    assign start_ok  = start_req && !(ctl_rcsel && cpu_fast);
    assign start_bad = start_req && ctl_rcsel && cpu_fast;
    assign abort_evt = !in_idle && pdown_req && !src_rc_q;
    assign conv_tick = src_rc_q ? rc_tick : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            src_rc_q <= 1'b0;
            chan_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                src_rc_q <= ctl_rcsel;
                chan_q   <= ctl_chan;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_d = ctl_rcsel ? ST_SYNC : ST_CONV;
            ST_SYNC: begin
                if (abort_evt)      state_d = ST_IDLE;
                else if (sync_last) state_d = ST_CONV;
            end
            ST_CONV: begin
                if (abort_evt)                 state_d = ST_IDLE;
                else if (conv_tick && sar_last) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = !in_idle;
        sync_run = (state_q == ST_SYNC) && !abort_evt;
        sar_load = start_ok;
        sar_step = (state_q == ST_CONV) && conv_tick && !abort_evt;
        done_evt = (state_q == ST_DONE) && !abort_evt;
        chan     = chan_q;
    end

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(ctl_we && ctl_start)) |=> (state_q == ST_IDLE));
    a_r9_abort_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && pdown_req && !src_rc_q) |=> (state_q == ST_IDLE));
    a_r10_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ctl_we && ctl_start && ctl_rcsel && cpu_fast) |=> (state_q == ST_IDLE));
    a_r3_sync_only_rc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC) |-> src_rc_q);
endmodule

// File: rtl/adc_status.sv
module adc_status #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_ie,
    input  logic             ctl_flag_clr,
    input  logic             idle_req,
    input  logic             pdown_req,
    input  logic             done_evt,
    input  logic             abort_evt,
    input  logic             start_ok,
    input  logic             start_bad,
    input  logic [RES_W-1:0] acc,
    output logic [RES_W-1:0] result,
    output logic             done_flag,
    output logic             irq,
    output logic             wake,
    output logic             result_valid,
    output logic             cfg_err
);
    logic [RES_W-1:0] res_q;
    logic             flag_q, ie_q, wake_q, valid_q, err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flag_q  <= 1'b0;
            ie_q    <= 1'b0;
            wake_q  <= 1'b0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (ctl_we)
                ie_q <= ctl_ie;
            if (done_evt)
                flag_q <= 1'b1;
            else if (ctl_we && ctl_flag_clr)
                flag_q <= 1'b0;
            if (done_evt) begin
                res_q   <= acc;
                valid_q <= 1'b1;
            end else if (abort_evt) begin
                valid_q <= 1'b0;
            end
            wake_q <= done_evt && ie_q && (idle_req || pdown_req);
            if (start_bad)
                err_q <= 1'b1;
            else if (start_ok)
                err_q <= 1'b0;
        end
    end

    assign result       = res_q;
    assign done_flag    = flag_q;
    assign irq          = flag_q && ie_q;
    assign wake         = wake_q;
    assign result_valid = valid_q;
    assign cfg_err      = err_q;

    a_r5_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(done_evt));
    a_r7_wake_source: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> $past(done_evt));
    a_r6_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(done_evt));
    a_r9_abort_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> !valid_q);
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl #(
    parameter int RES_W    = 8,
    parameter int CH_W     = 2,
    parameter int SYNC_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_start,
    input  logic [CH_W-1:0]  ctl_chan,
    input  logic             ctl_rcsel,
    input  logic             ctl_ie,
    input  logic             ctl_flag_clr,
    input  logic             cpu_fast,
    input  logic             rc_tick,
    input  logic             idle_req,
    input  logic             pdown_req,
    input  logic             cmp_in,
    output logic [CH_W-1:0]  mux_sel,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             busy,
    output logic             done_flag,
    output logic             irq,
    output logic             wake,
    output logic             result_valid,
    output logic             cfg_err
);
    logic             sync_run, sync_last;
    logic             sar_load, sar_step, sar_last;
    logic             done_evt, abort_evt, start_ok, start_bad;
    logic [RES_W-1:0] acc;

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_start (ctl_start),
        .ctl_chan  (ctl_chan),
        .ctl_rcsel (ctl_rcsel),
        .cpu_fast  (cpu_fast),
        .rc_tick   (rc_tick),
        .pdown_req (pdown_req),
        .sync_last (sync_last),
        .sar_last  (sar_last),
        .chan      (mux_sel),
        .busy      (busy),
        .sync_run  (sync_run),
        .sar_load  (sar_load),
        .sar_step  (sar_step),
        .done_evt  (done_evt),
        .abort_evt (abort_evt),
        .start_ok  (start_ok),
        .start_bad (start_bad)
    );

    adc_sync_cnt #(.SYNC_CYC(SYNC_CYC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sync_run),
        .last  (sync_last)
    );

    adc_sar_core #(.RES_W(RES_W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sar_load),
        .step   (sar_step),
        .cmp_in (cmp_in),
        .trial  (dac_code),
        .acc    (acc),
        .last   (sar_last)
    );

    adc_status #(.RES_W(RES_W)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_we       (ctl_we),
        .ctl_ie       (ctl_ie),
        .ctl_flag_clr (ctl_flag_clr),
        .idle_req     (idle_req),
        .pdown_req    (pdown_req),
        .done_evt     (done_evt),
        .abort_evt    (abort_evt),
        .start_ok     (start_ok),
        .start_bad    (start_bad),
        .acc          (acc),
        .result       (result),
        .done_flag    (done_flag),
        .irq          (irq),
        .wake         (wake),
        .result_valid (result_valid),
        .cfg_err      (cfg_err)
    );

    a_r4_busy_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wake);
endmodule

// File: tb/sim_adc_pwr_ctrl.sv
module sim_adc_pwr_ctrl;
    localparam int CLK_P = 10;
    localparam int SYNC  = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_we = 0, ctl_start = 0, ctl_rcsel = 0, ctl_ie = 0, ctl_flag_clr = 0;
    logic [1:0] ctl_chan = 0;
    logic cpu_fast = 0, rc_tick, idle_req = 0, pdown_req = 0, cmp_in;
    logic [1:0] mux_sel;
    logic [7:0] dac_code, result;
    logic busy, done_flag, irq, wake, result_valid, cfg_err;

    logic [7:0] ain [4];
    logic       rc_sparse = 0;
    int         rc_cnt = 0;
    int         checks = 0, errors = 0;
    bit         finished = 0;

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) rc_cnt <= (rc_cnt == 2) ? 0 : rc_cnt + 1;
    assign rc_tick = rc_sparse ? (rc_cnt == 0) : 1'b1;
    assign cmp_in  = (ain[mux_sel] >= dac_code);

    adc_pwr_ctrl #(.RES_W(8), .CH_W(2), .SYNC_CYC(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(ctl_start),
        .ctl_chan(ctl_chan), .ctl_rcsel(ctl_rcsel), .ctl_ie(ctl_ie),
        .ctl_flag_clr(ctl_flag_clr), .cpu_fast(cpu_fast), .rc_tick(rc_tick),
        .idle_req(idle_req), .pdown_req(pdown_req), .cmp_in(cmp_in),
        .mux_sel(mux_sel), .dac_code(dac_code), .result(result), .busy(busy),
        .done_flag(done_flag), .irq(irq), .wake(wake),
        .result_valid(result_valid), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic st, input logic [1:0] ch, input logic rs,
                      input logic ie, input logic clr);
        @(negedge clk);
        ctl_we = 1; ctl_start = st; ctl_chan = ch; ctl_rcsel = rs;
        ctl_ie = ie; ctl_flag_clr = clr;
        @(negedge clk);
        ctl_we = 0; ctl_start = 0; ctl_flag_clr = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < 4; i++) ain[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !done_flag && !irq && !wake, "R11 flags", int'(busy), 0);
        chk(!result_valid && !cfg_err && mux_sel == 0 && result == 0,
            "R11 status", int'(result), 0);

        // R1 R2 R3 sweep with CPU source
        for (int ch = 0; ch < 4; ch++) begin
            for (int v = 0; v < 256; v++) begin
                for (int k = 0; k < 4; k++) ain[k] = ~8'(v);
                ain[ch] = 8'(v);
                wr(1, 2'(ch), 0, 0, 0);
                chk(mux_sel == 2'(ch), "R1 channel", int'(mux_sel), ch);
                wait_idle(n);
                chk(result == 8'(v), "R2 result cpu", int'(result), v);
                chk(n == 9, "R3 cpu busy length", n, 9);
            end
        end

        // R3 RC source, tick every cycle
        ain[1] = 8'hC3;
        wr(1, 1, 1, 0, 0);
        wait_idle(n);
        chk(n == SYNC + 9, "R3 rc busy length", n, SYNC + 9);
        chk(result == 8'hC3, "R3 rc result", int'(result), 8'hC3);

        // R2 R3 sweep with sparse RC tick
        rc_sparse = 1;
        for (int v = 0; v < 256; v++) begin
            ain[2] = 8'(v);
            wr(1, 2, 1, 0, 0);
            wait_idle(n);
            chk(result == 8'(v), "R3 rc sparse result", int'(result), v);
        end
        rc_sparse = 0;

        // R4 start while busy ignored, R1 channel held
        ain[1] = 8'h5A; ain[3] = 8'h11;
        wr(1, 1, 0, 0, 0);
        wr(1, 3, 0, 0, 0);
        chk(mux_sel == 1, "R4 R1 channel held", int'(mux_sel), 1);
        wait_idle(n);
        chk(n == 7, "R4 remaining busy", n, 7);
        chk(result == 8'h5A, "R4 result", int'(result), 8'h5A);

        // R5 flag and irq
        chk(done_flag == 1, "R5 flag set", int'(done_flag), 1);
        chk(irq == 0, "R5 irq masked", int'(irq), 0);
        wr(0, 0, 0, 1, 0);
        chk(irq == 1, "R5 irq enabled", int'(irq), 1);
        wr(0, 0, 0, 1, 1);
        chk(done_flag == 0 && irq == 0, "R5 flag cleared", int'(done_flag), 0);

        // R7 idle with ie: wake
        idle_req = 1; ain[0] = 8'h3C;
        wr(1, 0, 0, 1, 0);
        wait_idle(n);
        chk(wake == 1, "R7 wake idle ie", int'(wake), 1);
        chk(result == 8'h3C, "R7 result idle", int'(result), 8'h3C);
        @(negedge clk);
        chk(wake == 0, "R7 wake one cycle", int'(wake), 0);
        // R7 idle without ie: no wake
        wr(1, 0, 0, 0, 0);
        wait_idle(n);
        chk(wake == 0, "R7 no wake without ie", int'(wake), 0);
        idle_req = 0;

        // R8 power down with RC source
        ain[3] = 8'h81;
        wr(1, 3, 1, 1, 1);
        pdown_req = 1;
        wait_idle(n);
        chk(n == SYNC + 9, "R8 rc completes length", n, SYNC + 9);
        chk(wake == 1 && result == 8'h81, "R8 wake and result", int'(result), 8'h81);
        chk(result_valid == 1, "R6 valid after completion", int'(result_valid), 1);
        pdown_req = 0;
        wr(0, 0, 0, 1, 1);

        // R9 power down with CPU source aborts
        ain[0] = 8'h07;
        wr(1, 0, 0, 1, 0);
        pdown_req = 1;
        @(negedge clk);
        chk(busy == 0, "R9 abort busy", int'(busy), 0);
        chk(done_flag == 0 && wake == 0, "R9 no flag no wake", int'(wake), 0);
        chk(result_valid == 0, "R9 R6 invalid", int'(result_valid), 0);
        chk(result == 8'h81, "R9 result kept", int'(result), 8'h81);
        @(negedge clk);
        chk(wake == 0 && done_flag == 0, "R9 no late wake", int'(wake), 0);
        pdown_req = 0;

        // R6 valid again after good conversion
        wr(1, 0, 0, 0, 0);
        wait_idle(n);
        chk(result_valid == 1 && result == 8'h07, "R6 valid restored", int'(result), 8'h07);

        // R10 fast CPU clock refuses RC start
        cpu_fast = 1;
        wr(1, 0, 1, 0, 0);
        chk(busy == 0, "R10 refused start", int'(busy), 0);
        chk(cfg_err == 1, "R10 error set", int'(cfg_err), 1);
        ain[2] = 8'hE4;
        wr(1, 2, 0, 0, 0);
        chk(busy == 1 && cfg_err == 0, "R10 cpu start clears error", int'(cfg_err), 0);
        wait_idle(n);
        chk(result == 8'hE4, "R10 result", int'(result), 8'hE4);
        cpu_fast = 0;

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule